// File: doc/BRIEF.md
# Saturating Symbol-Count Recognizer

This block is a streaming recognizer. On each clock cycle it takes at most one symbol from a two-letter alphabet: a neutral letter and a counted letter. It keeps track of how many counted letters it has seen so far. The count is held in four states. ST_ZERO, ST_ONE and ST_TWO mean exactly zero, one or two counted letters. ST_SAT is an absorbing state that stands for three or more. A running accept bit reports on every cycle whether the current state is the accepting one.

A separate end-of-input code lies outside the alphabet and closes a string. On the cycle after it arrives, the block raises a one-cycle done pulse and a registered final verdict. It then restarts in ST_ZERO, so the next string can begin at once. A mode input selects the accepting state. By default the block accepts exactly two counted letters (ST_TWO). With the mode input set, it accepts a saturated count (ST_SAT) instead.

The state transitions are as follows. A counted letter moves ST_ZERO to ST_ONE, ST_ONE to ST_TWO, ST_TWO to ST_SAT, and ST_SAT back to ST_SAT. The neutral letter, the reserved code and idle cycles hold the state in every state. End-of-input moves every state to ST_ZERO.

Top module: `symcnt_recognizer`

## Requirements
- R1: While `rst` is high at a clock edge (synchronous, active-high), the state becomes ST_ZERO and both `verdict_done` and `verdict_accept` become 0.
- R2: The code 2'b00 (neutral letter) with `sym_valid` high leaves the state unchanged.
- R3: The code 2'b01 (counted letter) with `sym_valid` high advances the state by one: ST_ZERO to ST_ONE, ST_ONE to ST_TWO, and ST_TWO to ST_SAT.
- R4: In ST_SAT, a counted letter keeps the state in ST_SAT, so three or more counted letters are absorbed there.
- R5: The reserved code 2'b10, and any cycle with `sym_valid` low, leaves the state unchanged.
- R6: `accept_now` is 1 exactly when the current state is the accepting state. The accepting state is ST_TWO when `accept_at_sat` is 0 and ST_SAT when it is 1. The bit follows the state with no added cycle.
- R7: The code 2'b11 (end-of-input) with `sym_valid` high raises `verdict_done` on the following cycle only. On that cycle `verdict_accept` equals the `accept_now` value of the cycle in which end-of-input was presented.
- R8: After end-of-input the state returns to ST_ZERO, and a symbol presented on the very next cycle counts as the first symbol of a new string.
- R9: `verdict_accept` holds its value on every cycle that does not follow an end-of-input.
- R10: With the default mode, the string abaabaa followed by end-of-input is accepted, and aaa, bbb and bbbb are rejected. With `accept_at_sat` set, bbb and bbbb are accepted, and abaabaa and aaa are rejected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | Qualifies `sym_code` for this cycle |
| sym_code | input | 2 | 00 neutral, 01 counted, 10 reserved, 11 end-of-input |
| accept_at_sat | input | 1 | 0: accept in ST_TWO, 1: accept in ST_SAT |
| accept_now | output | 1 | Accept decode of the current state |
| verdict_done | output | 1 | One-cycle pulse after end-of-input |
| verdict_accept | output | 1 | Registered final verdict, held between strings |

## Verification
The assertions assume that `sym_valid`, `sym_code` and `accept_at_sat` are driven to known values on every clock edge, including the edges during reset. They also assume that `accept_at_sat` is not changed in the same cycle as an end-of-input whose verdict is being compared. The bench drives every input away from the rising edge, from time zero onward. It changes the mode only between strings that end with end-of-input. Its random stimulus chooses among all four codes and idle cycles, so it never needs to drive an unknown value.

// File: rtl/symcnt_pkg.sv
package symcnt_pkg;

    localparam int SYM_W   = 2;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_ZERO = 2'd0,
        ST_ONE  = 2'd1,
        ST_TWO  = 2'd2,
        ST_SAT  = 2'd3
    } cnt_state_t;

    typedef enum logic [SYM_W-1:0] {
        SYM_NEUTRAL = 2'b00,
        SYM_COUNTED = 2'b01,
        SYM_RESERVE = 2'b10,
        SYM_EOI     = 2'b11
    } sym_code_t;

    typedef struct packed {
        logic hold;     // neutral, reserved or idle
        logic bump;     // counted letter
        logic close;    // end-of-input
    } sym_class_t;

endpackage

// File: rtl/symcnt_decode.sv
module symcnt_decode
    import symcnt_pkg::*;
(
    input  logic             valid_i,
    input  logic [SYM_W-1:0] code_i,
    output sym_class_t       cls_o
);

    always_comb begin
        cls_o = '{hold: 1'b1, bump: 1'b0, close: 1'b0};
        if (valid_i) begin
            unique case (sym_code_t'(code_i))
                SYM_COUNTED: cls_o = '{hold: 1'b0, bump: 1'b1, close: 1'b0};
                SYM_EOI:     cls_o = '{hold: 1'b0, bump: 1'b0, close: 1'b1};
                SYM_NEUTRAL: cls_o = '{hold: 1'b1, bump: 1'b0, close: 1'b0};
                SYM_RESERVE: cls_o = '{hold: 1'b1, bump: 1'b0, close: 1'b0};
                default:     cls_o = '{hold: 1'b1, bump: 1'b0, close: 1'b0};
            endcase
        end
    end

endmodule

// File: rtl/symcnt_next.sv
module symcnt_next
    import symcnt_pkg::*;
(
    input  cnt_state_t cur_i,
    input  sym_class_t cls_i,
    output cnt_state_t nxt_o
);

    always_comb begin
        nxt_o = cur_i;
        if (cls_i.close) begin
            nxt_o = ST_ZERO;
        end else if (cls_i.bump) begin
            unique case (cur_i)
                ST_ZERO: nxt_o = ST_ONE;
                ST_ONE:  nxt_o = ST_TWO;
                ST_TWO:  nxt_o = ST_SAT;
                ST_SAT:  nxt_o = ST_SAT;
                default: nxt_o = ST_ZERO;
            endcase
        end
    end

endmodule

// File: rtl/symcnt_verdict.sv
module symcnt_verdict
    import symcnt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cnt_state_t state_i,
    input  logic       sat_mode_i,
    input  logic       close_i,
    output logic       accept_now_o,
    output logic       done_o,
    output logic       verdict_o
);

    cnt_state_t target;

    always_comb begin
        target       = sat_mode_i ? ST_SAT : ST_TWO;
        accept_now_o = (state_i == target);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o    <= 1'b0;
            verdict_o <= 1'b0;
        end else begin
            done_o <= close_i;
            if (close_i) begin
                verdict_o <= accept_now_o;
            end
        end
    end

    AST_VERDICT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        close_i |=> (done_o && verdict_o == $past(accept_now_o)))
        else $error("verdict capture"); // R7

    AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !close_i |=> (!done_o && $stable(verdict_o)))
        else $error("verdict hold"); // R9

endmodule

// File: rtl/symcnt_recognizer.sv
module symcnt_recognizer
    import symcnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sym_valid,
    input  logic [SYM_W-1:0] sym_code,
    input  logic             accept_at_sat,
    output logic             accept_now,
    output logic             verdict_done,
    output logic             verdict_accept
);

    sym_class_t cls;
    cnt_state_t state_q;
    cnt_state_t state_d;

    symcnt_decode u_decode (
        .valid_i (sym_valid),
        .code_i  (sym_code),
        .cls_o   (cls)
    );

    symcnt_next u_next (
        .cur_i (state_q),
        .cls_i (cls),
        .nxt_o (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ZERO;
        end else begin
            state_q <= state_d;
        end
    end

    symcnt_verdict u_verdict (
        .clk          (clk),
        .rst          (rst),
        .state_i      (state_q),
        .sat_mode_i   (accept_at_sat),
        .close_i      (cls.close),
        .accept_now_o (accept_now),
        .done_o       (verdict_done),
        .verdict_o    (verdict_accept)
    );

    AST_HOLD_STATE: assert property (@(posedge clk) disable iff (rst)
        (!sym_valid || sym_code == SYM_NEUTRAL || sym_code == SYM_RESERVE)
        |=> $stable(state_q))
        else $error("state moved on hold"); // R5

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym_code == SYM_COUNTED && state_q != ST_SAT)
        |=> (state_q == cnt_state_t'($past(state_q) + 2'd1)))
        else $error("count step"); // R3

    AST_ABSORB: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym_code == SYM_COUNTED && state_q == ST_SAT)
        |=> state_q == ST_SAT)
        else $error("saturation left"); // R4

    AST_RESTART: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym_code == SYM_EOI) |=> state_q == ST_ZERO)
        else $error("no restart"); // R8

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (state_q == ST_ZERO && !verdict_done))
        else $error("reset state"); // R1

endmodule

// File: tb/symcnt_recognizer_tb.sv
`timescale 1ns/1ps
module symcnt_recognizer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_valid = 1'b0;
    logic [1:0] sym_code = 2'b00;
    logic       accept_at_sat = 1'b0;
    logic       accept_now;
    logic       verdict_done;
    logic       verdict_accept;

    int n_vec = 0;
    int n_bad = 0;
    bit reported = 0;

    int  m_cnt = 0;       // model count, saturating at 3
    bit  m_done = 0;
    bit  m_verd = 0;

    always #4 clk = ~clk;

    symcnt_recognizer dut_i (
        .clk            (clk),
        .rst            (rst),
        .sym_valid      (sym_valid),
        .sym_code       (sym_code),
        .accept_at_sat  (accept_at_sat),
        .accept_now     (accept_now),
        .verdict_done   (verdict_done),
        .verdict_accept (verdict_accept)
    );

    function automatic bit exp_accept(int cnt, bit sat);
        return sat ? (cnt == 3) : (cnt == 2);
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // Called at a negedge: drive one symbol, advance a cycle, check outputs.
    task automatic step(bit v, logic [1:0] c);
        check("R6 accept_now before edge", accept_now, exp_accept(m_cnt, accept_at_sat));
        sym_valid = v;
        sym_code  = c;
        m_done = 0;
        if (v) begin
            case (c)
                2'b01: if (m_cnt < 3) m_cnt++;
                2'b11: begin
                    m_done = 1;
                    m_verd = exp_accept(m_cnt, accept_at_sat);
                    m_cnt  = 0;
                end
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        check("R7 verdict_done", verdict_done, m_done);
        check("R7/R9 verdict_accept", verdict_accept, m_verd);
        check("R2/R3/R4/R5/R8 accept_now after edge", accept_now,
              exp_accept(m_cnt, accept_at_sat));
    endtask

    task automatic run_string(string s, bit exp_v, string tag);
        foreach (s[i]) step(1'b1, (s[i] == "b") ? 2'b01 : 2'b00);
        step(1'b1, 2'b11);
        check(tag, verdict_accept, exp_v);
        check(tag, verdict_done, 1'b1);
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

    initial begin
        int seed;
        seed = 32'h5A17;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 verdict_done in reset", verdict_done, 1'b0);
        check("R1 verdict_accept in reset", verdict_accept, 1'b0);
        check("R1 accept_now in reset", accept_now, 1'b0);
        rst = 1'b0;

        // R10 directed, default mode
        run_string("abaabaa", 1'b1, "R10 abaabaa s2");
        run_string("aaa",     1'b0, "R10 aaa s2");
        run_string("bbb",     1'b0, "R10 bbb s2");
        run_string("bbbb",    1'b0, "R10 bbbb s2");
        accept_at_sat = 1'b1;
        run_string("abaabaa", 1'b0, "R10 abaabaa s3");
        run_string("aaa",     1'b0, "R10 aaa s3");
        run_string("bbb",     1'b1, "R10 bbb s3");
        run_string("bbbb",    1'b1, "R10 bbbb s3");
        accept_at_sat = 1'b0;

        // R5: reserved code and idle cycles between counted letters
        step(1'b1, 2'b01);
        step(1'b1, 2'b10);
        step(1'b0, 2'b01);
        step(1'b1, 2'b01);
        check("R5 reserved/idle ignored, two counted seen", accept_now, 1'b1);
        // R8: back-to-back end-of-input, then immediate new string
        step(1'b1, 2'b11);
        step(1'b1, 2'b11);
        check("R8 empty string rejected", verdict_accept, 1'b0);
        step(1'b1, 2'b01);
        step(1'b1, 2'b01);
        check("R8 new string counts from zero", accept_now, 1'b1);
        step(1'b1, 2'b11);

        // Random stimulus, mode changed only right after an end-of-input
        for (int k = 0; k < 4000; k++) begin
            int r;
            r = int'($urandom_range(0, 9));
            if (r == 0)      step(1'b0, 2'($urandom_range(0, 3)));
            else if (r < 4)  step(1'b1, 2'b00);
            else if (r < 7)  step(1'b1, 2'b01);
            else if (r == 7) step(1'b1, 2'b10);
            else begin
                step(1'b1, 2'b11);
                accept_at_sat = 1'($urandom_range(0, 1));
            end
        end

        // R1: reset mid-string clears state and verdict
        step(1'b1, 2'b01);
        step(1'b1, 2'b01);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_cnt = 0; m_verd = 0; m_done = 0;
        check("R1 verdict_accept after reset", verdict_accept, 1'b0);
        check("R1 accept_now after reset", accept_now, exp_accept(0, accept_at_sat));
        step(1'b1, 2'b00);
        report();
    end

endmodule